// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block is a master-side helper that frees a two-wire serial bus when a memory slave has lost track of the protocol after a power glitch, a system reset or a broken transfer. A single start pulse runs a fixed pattern on the bus. The pattern is a START, then nine free clock pulses with the data line released, then a second START followed at once by a STOP. The slave sees that second START with no address or data after it, which puts it back in its idle state. An ordinary transfer engine cannot produce that pattern.

Both lines work as open-drain lines. For each line the block has an enable that pulls the line low and an input that reads the real level. The block never drives a line high. A half-period divider, loaded when the start pulse is taken, sets the minimum length of every bus phase. The block only enforces minimum times. A phase that waits for SCL to go high can last as long as the slave holds SCL low, so stretching is tolerated. The `busy` and `done` flags report progress. The block has no data stream, so there is no valid/ready handshake.

Top module: `bus_unstick`

## Requirements
- R1: After reset, and whenever `busy` is low, `scl_oe` and `sda_oe` are both 0 (lines released) and `done` is 0.
- R2: `go` sampled high while idle makes `busy` high from the next cycle. The first phase leaves both lines released, and the second phase pulls SDA (`sda_oe`=1) while SCL stays released, which forms the first START.
- R3: After the first START and a hold phase with both lines low, SCL is pulsed exactly 9 times with `sda_oe`=0. Each pulse is a low phase followed by a released phase. SCL is then pulled low once more before it is released for the second START, so `scl_oe` falls from 1 to 0 exactly 10 times per run, and `sda_oe` rises exactly twice.
- R4: Every phase lasts H = `half_div`+1 clock cycles, or a whole multiple of H. A phase that releases SCL for a clock high or for the second START moves on only at a half-period boundary at which `scl_in` reads 1. A run on a bus that never holds a line low lasts exactly 25·H cycles of `busy`.
- R5: For the second START, SCL is released and read back high, and SDA is then pulled low for one half-period. After that SDA is released with SCL still released, which forms the STOP. The STOP phase ends only at a boundary where both `scl_in` and `sda_in` read 1.
- R6: The cycle after the STOP phase ends, `done` is 1 for exactly one cycle, `busy` is 0 and both lines are released.
- R7: `go` while `busy` is high is ignored: the run length and the line pattern do not change.
- R8: `scl_oe` and `sda_oe` never change in the same cycle.
- R9: `half_div` is sampled only when `go` is taken. A change during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start request, taken only when idle |
| half_div | input | DIV_W | Half-period length minus one, in clock cycles |
| scl_in | input | 1 | Level read back from the clock line |
| sda_in | input | 1 | Level read back from the data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence completes |

## Verification
A wrong phase state shows up on `scl_oe` or `sda_oe` within one half-period. A wrong divider count moves a line edge by at least one cycle, at the first phase boundary after the fault. A wrong pulse count shows up as a wrong number of clock releases, or as a second START placed at the wrong half-period, and is caught before `done` rises. Stretched SCL and a slave holding SDA low push the phase boundaries out, so a design that skips the read-back of a line shows a line edge in the wrong cycle at that boundary.

// File: rtl/bus_unstick_pkg.sv
package bus_unstick_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_START1, ST_GRAB, ST_LO, ST_HI,
    ST_LO2, ST_RISE, ST_START2, ST_STOP
  } phase_e;
endpackage

// File: rtl/bus_unstick_div.sv
module bus_unstick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  input  logic             run,
  output logic             tick
);
  logic [DIV_W-1:0] lim_q;
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      lim_q <= load_val;
      cnt_q <= '0;
    end else if (run) begin
      if (tick) cnt_q <= '0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bus_unstick_seq.sv
module bus_unstick_seq
  import bus_unstick_pkg::*;
#(
  parameter int NPULSE = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic tick,
  input  logic scl_in,
  input  logic sda_in,
  output logic accept,
  output logic busy,
  output logic done,
  output logic scl_oe,
  output logic sda_oe
);
  localparam int PW = $clog2(NPULSE + 1);
  localparam logic [PW-1:0] LAST = PW'(NPULSE - 1);

  phase_e        st_q, st_d;
  logic [PW-1:0] pulse_q;
  logic          done_q;
  logic          adv;

  assign accept = go && (st_q == ST_IDLE);
  assign busy   = (st_q != ST_IDLE);
  assign done   = done_q;
  assign scl_oe = (st_q == ST_GRAB) || (st_q == ST_LO) || (st_q == ST_LO2);
  assign sda_oe = (st_q == ST_START1) || (st_q == ST_GRAB) || (st_q == ST_START2);

  always_comb begin
    case (st_q)
      ST_HI, ST_RISE: adv = tick && scl_in;
      ST_STOP:        adv = tick && scl_in && sda_in;
      default:        adv = tick;
    endcase
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (go) st_d = ST_PRE;
      ST_PRE:    if (adv) st_d = ST_START1;
      ST_START1: if (adv) st_d = ST_GRAB;
      ST_GRAB:   if (adv) st_d = ST_LO;
      ST_LO:     if (adv) st_d = ST_HI;
      ST_HI:     if (adv) st_d = (pulse_q == LAST) ? ST_LO2 : ST_LO;
      ST_LO2:    if (adv) st_d = ST_RISE;
      ST_RISE:   if (adv) st_d = ST_START2;
      ST_START2: if (adv) st_d = ST_STOP;
      ST_STOP:   if (adv) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pulse_q <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_STOP) && adv;
      if (accept)                       pulse_q <= '0;
      else if ((st_q == ST_HI) && adv)  pulse_q <= pulse_q + 1'b1;
    end
  end
endmodule

// File: rtl/bus_unstick.sv
module bus_unstick #(
  parameter int DIV_W  = 8,
  parameter int NPULSE = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DIV_W-1:0] half_div,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic             done
);
  logic accept;
  logic tick;

  bus_unstick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(half_div),
    .run(busy), .tick(tick)
  );

  bus_unstick_seq #(.NPULSE(NPULSE)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .tick(tick),
    .scl_in(scl_in), .sda_in(sda_in), .accept(accept), .busy(busy),
    .done(done), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/bus_unstick_chk.sv
module bus_unstick_chk (
  input logic clk,
  input logic rst_n,
  input logic go,
  input logic busy,
  input logic done,
  input logic scl_oe,
  input logic sda_oe
);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));
  // R2
  go_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> busy);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R8
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_oe) |-> $stable(sda_oe));
endmodule

bind bus_unstick bus_unstick_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done),
  .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/sim_bus_unstick.sv
module sim_bus_unstick;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go = 1'b0;
  logic [7:0] half_div = 8'd0;
  logic       scl_hold = 1'b0;
  logic       sda_hold = 1'b0;
  logic       scl_oe, sda_oe, busy, done;
  logic       scl_in, sda_in;

  assign scl_in = !(scl_oe || scl_hold);
  assign sda_in = !(sda_oe || sda_hold);

  always #2 clk = ~clk;

  bus_unstick u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .half_div(half_div),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(busy), .done(done)
  );

  typedef struct packed { logic scl; logic sda; logic ws; logic wd; } ph_t;
  ph_t q[$];
  int  m_c, m_d;
  bit  m_done;
  int  chk = 0, fail = 0, cyc = 0;
  int  run_len, rel_cnt, sda_rise;
  logic p_scl, p_sda;

  function automatic void push(logic s, logic d, logic ws, logic wd);
    ph_t p;
    p.scl = s; p.sda = d; p.ws = ws; p.wd = wd;
    q.push_back(p);
  endfunction

  function automatic void build();
    q.delete();
    push(0, 0, 0, 0);   // idle setup
    push(0, 1, 0, 0);   // first START
    push(1, 1, 0, 0);   // hold low
    for (int i = 0; i < 9; i++) begin
      push(1, 0, 0, 0); // clock low, data free
      push(0, 0, 1, 0); // clock high, wait read-back
    end
    push(1, 0, 0, 0);   // low before second START
    push(0, 0, 1, 0);   // raise clock, wait read-back
    push(0, 1, 0, 0);   // second START
    push(0, 0, 1, 1);   // STOP, wait both high
  endfunction

  // reference model, updated at the active edge
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_c = 0; m_d = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (q.size() == 0) begin
        if (go) begin m_d = int'(half_div); build(); m_c = 0; end
      end else if (m_c == m_d) begin
        m_c = 0;
        if ((!q[0].ws || scl_in) && (!q[0].wd || sda_in)) begin
          void'(q.pop_front());
          if (q.size() == 0) m_done = 1;
        end
      end else m_c++;
    end
  end

  task automatic check(string tag, int act, int exp);
    chk++;
    if (act != exp) begin
      fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison and event counting, away from the edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      logic es, ed;
      es = (q.size() != 0) ? q[0].scl : 1'b0;
      ed = (q.size() != 0) ? q[0].sda : 1'b0;
      check("R2/R3/R4/R5 scl_oe", int'(scl_oe), int'(es));
      check("R2/R3/R4/R5 sda_oe", int'(sda_oe), int'(ed));
      check("R2/R7 busy", int'(busy), int'(q.size() != 0));
      check("R6 done", int'(done), int'(m_done));
      if (busy) run_len++;
      if (p_scl && !scl_oe) rel_cnt++;
      if (!p_sda && sda_oe) sda_rise++;
    end
    p_scl = scl_oe; p_sda = sda_oe;
    if (cyc == 150000) begin
      fail++; chk++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", chk - fail, chk);
      $finish;
    end
  end

  task automatic start_run(int d);
    @(negedge clk);
    run_len = 0; rel_cnt = 0; sda_rise = 0;
    half_div = 8'(d); go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    check("R6 busy low at done", int'(busy), 0);
    check("R6 lines released at done", int'(scl_oe || sda_oe), 0);
    @(negedge clk);
    check("R6 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R1 scl_oe reset", int'(scl_oe), 0);
    check("R1 sda_oe reset", int'(sda_oe), 0);
    check("R1 busy reset", int'(busy), 0);
    check("R1 done reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3 R4: fastest divider
    start_run(0);
    wait_done();
    check("R4 run length H=1", run_len, 25);
    check("R3 scl releases", rel_cnt, 10);
    check("R3 sda pulls", sda_rise, 2);

    // R4: wider divider
    start_run(3);
    wait_done();
    check("R4 run length H=4", run_len, 100);
    check("R3 scl releases H=4", rel_cnt, 10);

    // R4: slave stretches the clock
    start_run(2);
    repeat (20) @(negedge clk);
    scl_hold = 1'b1;
    repeat (7) @(negedge clk);
    scl_hold = 1'b0;
    wait_done();
    check("R4 stretched run longer", int'(run_len > 75), 1);
    check("R3 scl releases stretched", rel_cnt, 10);

    // R7 R9: go and divider change during a run
    start_run(1);
    repeat (10) @(negedge clk);
    half_div = 8'd5; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    wait_done();
    check("R7 R9 run length unchanged", run_len, 50);
    check("R7 sda pulls unchanged", sda_rise, 2);

    // R5: slave holds SDA low past the second START
    start_run(1);
    repeat (30) @(negedge clk);
    sda_hold = 1'b1;
    repeat (30) @(negedge clk);
    sda_hold = 1'b0;
    wait_done();
    check("R5 stop waits for sda", int'(run_len > 50), 1);
    check("R5 sda pulls", sda_rise, 2);

    repeat (4) @(negedge clk);
    check("R1 idle after runs", int'(scl_oe || sda_oe || busy), 0);
    $display("%0d/%0d checks passed", chk - fail, chk);
    $finish;
  end
endmodule